// File: doc/BRIEF.md
# Dynamic Voltage Step Ramp Controller

This block produces the digital voltage code for a group of step-down regulator channels. Each channel holds three programmed set points: one for normal running, one for standby and one for the raised dynamic-scaling level. Two hardware pins per channel pick which set point is active. The code then walks toward that set point one 25 mV step at a time. The time between steps is set per channel by a 2-bit speed field, counted in ticks of an external prescaled timebase. The analog converter downstream therefore sees a smooth ramp rather than a jump.

Voltage is encoded as code = (V − 0.9 V) / 25 mV, so code 0 is 0.9 V and code 32 is 1.70 V. A per-channel power-ready flag is low whenever the output code differs from the active set point. This holds for a ramp in either direction, so a processor can wait for it before raising its clock. When adjacent channels are ganged to share a load, a pairing input locks the register writes of every odd-numbered channel, so that only the even channel of each pair can be programmed.

Top module: `dvs_slew_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, every output code is 0, every power-ready flag is 1, and all set points and speed fields are 0.
- R2: A write selects a field by `wr_sel`: 0 normal, 1 standby, 2 dynamic, 3 speed (low two data bits). It takes effect from the clock edge that captures it. A set-point value above 32 is stored as 32.
- R3: The active target is the dynamic set point when that channel's `dvs_pin` is high, otherwise the standby set point when its `stby_pin` is high, otherwise the normal set point.
- R4: While the code differs from the target, it changes by exactly one toward the target each time P ticks have been counted. P is 1, 2, 4 or 8 for speed 0, 1, 2 or 3. The tick count restarts at zero whenever the code equals the target.
- R5: `pwr_rdy` for a channel is low in exactly those cycles in which its code differs from its target, whether the ramp goes up or down.
- R6: If the target changes during a ramp, the code heads for the new target from its present value and keeps its partial tick count.
- R7: While `pair_mode` is high, writes addressed to odd-numbered channels are ignored and writes to even channels work normally.
- R8: In cycles with `tick` low, no output code changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled timebase pulse, one cycle per tick |
| pair_mode | input | 1 | Locks writes to odd-numbered channels |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CHW | Channel addressed by the write |
| wr_sel | input | 2 | Field: 0 normal, 1 standby, 2 dynamic, 3 speed |
| wr_data | input | 6 | Set-point code, or speed in bits 1:0 |
| stby_pin | input | NCH | Per-channel standby select |
| dvs_pin | input | NCH | Per-channel dynamic-level select (overrides standby) |
| code_o | output | NCH*6 | Output voltage codes, channel c at bits c*6 +: 6 |
| pwr_rdy | output | NCH | Per-channel power-ready flags |

## Verification
The ramp is driven up and down by spans of 1, 3 and 7 steps under all four speeds. The measured cycle count equals span times period, which separates a wrong period from a wrong step size or a stalled counter. Every set-point value from 0 to 63 is written in turn, which exposes clamping errors at and beyond 32. All four pin combinations expose the select priority. A reversal mid-ramp, a locked write with pairing on and then off, and runs with the timebase held off or pulsed every third cycle single out R6, R7 and R8. A cycle-level reference model is compared against both channels in every cycle.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
    localparam int CW       = 6;   // code width
    localparam int CODE_MAX = 32;  // 1.70 V
    localparam int SPD_W    = 2;
    localparam int CNT_W    = 3;   // holds up to period 8 minus one

    typedef logic [CW-1:0] code_t;

    typedef enum logic [1:0] {
        SEL_NORM  = 2'd0,
        SEL_STBY  = 2'd1,
        SEL_DVS   = 2'd2,
        SEL_SPEED = 2'd3
    } wsel_e;

    typedef struct packed {
        code_t             norm;
        code_t             stby;
        code_t             dvs;
        logic [SPD_W-1:0]  spd;
    } chan_cfg_t;

    function automatic code_t clamp_code(input code_t v);
        return (v > code_t'(CODE_MAX)) ? code_t'(CODE_MAX) : v;
    endfunction

    function automatic logic [CNT_W:0] step_period(input logic [SPD_W-1:0] s);
        return (CNT_W+1)'(1) << s;
    endfunction
endpackage

// File: rtl/dvs_cfg_regs.sv
module dvs_cfg_regs
    import dvs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic      lock,
    input  wsel_e     wr_sel,
    input  code_t     wr_data,
    output chan_cfg_t cfg_o
);
    chan_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;                       // R1
        end else if (wr_en && !lock) begin
            case (wr_sel)
                SEL_NORM:  cfg_q.norm <= clamp_code(wr_data);  // R2
                SEL_STBY:  cfg_q.stby <= clamp_code(wr_data);
                SEL_DVS:   cfg_q.dvs  <= clamp_code(wr_data);
                default:   cfg_q.spd  <= wr_data[SPD_W-1:0];
            endcase
        end
    end

    assign cfg_o = cfg_q;

    a_r2_set_points_capped: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.norm <= code_t'(CODE_MAX)) && (cfg_q.stby <= code_t'(CODE_MAX))
        && (cfg_q.dvs <= code_t'(CODE_MAX)));

    a_r7_locked_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && lock) |=> $stable(cfg_q));
endmodule

// File: rtl/dvs_tgt_sel.sv
module dvs_tgt_sel
    import dvs_pkg::*;
(
    input  chan_cfg_t cfg_i,
    input  logic      stby_i,
    input  logic      dvs_i,
    output code_t     tgt_o
);
    // R3: dynamic level outranks standby, standby outranks normal
    always_comb begin
        if (dvs_i)       tgt_o = cfg_i.dvs;
        else if (stby_i) tgt_o = cfg_i.stby;
        else             tgt_o = cfg_i.norm;
    end
endmodule

// File: rtl/dvs_ramp.sv
module dvs_ramp
    import dvs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  code_t            tgt_i,
    input  logic [SPD_W-1:0] spd_i,
    output code_t            code_o,
    output logic             rdy_o
);
    code_t            code_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   per;
    logic             at_tgt;
    logic             last;
    logic             go_up;

    always_comb begin
        per    = step_period(spd_i);
        at_tgt = (code_q == tgt_i);
        // >= keeps the ramp moving if the speed shrinks mid-ramp
        last   = ({1'b0, cnt_q} >= (per - (CNT_W+1)'(1)));
        go_up  = (tgt_i > code_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            cnt_q  <= '0;
        end else if (at_tgt) begin
            cnt_q  <= '0;                       // R4 restart at target
        end else if (tick) begin
            if (last) begin
                cnt_q  <= '0;
                code_q <= go_up ? code_q + code_t'(1) : code_q - code_t'(1);
            end else begin
                cnt_q  <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign code_o = code_q;
    assign rdy_o  = at_tgt;                     // R5

    a_r4_unit_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (code_q == $past(code_q)) || (code_q == $past(code_q) + code_t'(1))
                 || (code_q + code_t'(1) == $past(code_q)));

    a_r6_moves_toward_target: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((code_q <= $past(code_q)) || ($past(code_q) < $past(tgt_i)))
              && ((code_q >= $past(code_q)) || ($past(code_q) > $past(tgt_i))));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(code_q));
endmodule

// File: rtl/dvs_slew_ctrl.sv
module dvs_slew_ctrl
    import dvs_pkg::*;
#(
    parameter int NCH = 2,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              pair_mode,
    input  logic              wr_en,
    input  logic [CHW-1:0]    wr_ch,
    input  logic [1:0]        wr_sel,
    input  logic [CW-1:0]     wr_data,
    input  logic [NCH-1:0]    stby_pin,
    input  logic [NCH-1:0]    dvs_pin,
    output logic [NCH*CW-1:0] code_o,
    output logic [NCH-1:0]    pwr_rdy
);
    wsel_e sel;
    assign sel = wsel_e'(wr_sel);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        chan_cfg_t cfg;
        code_t     tgt;
        code_t     code;
        logic      we;
        logic      lock;

        assign we   = wr_en && (wr_ch == CHW'(ch));
        assign lock = pair_mode && ((ch % 2) == 1);   // R7

        dvs_cfg_regs u_regs (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (we),
            .lock    (lock),
            .wr_sel  (sel),
            .wr_data (wr_data),
            .cfg_o   (cfg)
        );

        dvs_tgt_sel u_sel (
            .cfg_i  (cfg),
            .stby_i (stby_pin[ch]),
            .dvs_i  (dvs_pin[ch]),
            .tgt_o  (tgt)
        );

        dvs_ramp u_ramp (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .tgt_i  (tgt),
            .spd_i  (cfg.spd),
            .code_o (code),
            .rdy_o  (pwr_rdy[ch])
        );

        assign code_o[ch*CW +: CW] = code;
    end
endmodule

// File: tb/dvs_slew_ctrl_bench.sv
`timescale 1ns/1ps
module dvs_slew_ctrl_bench;
    localparam int NCH = 2;
    localparam int CW  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic pair_mode = 1'b0;
    logic wr_en = 1'b0;
    logic [0:0] wr_ch = '0;
    logic [1:0] wr_sel = '0;
    logic [CW-1:0] wr_data = '0;
    logic [NCH-1:0] stby_pin = '0;
    logic [NCH-1:0] dvs_pin = '0;
    logic [NCH*CW-1:0] code_o;
    logic [NCH-1:0] pwr_rdy;

    int vecs = 0;
    int fails = 0;
    bit done = 0;
    bit mon_on = 0;

    // reference state
    int m_norm[NCH], m_stby[NCH], m_dvs[NCH], m_spd[NCH], m_code[NCH], m_cnt[NCH];

    always #2.5 clk = ~clk;   // 200 MHz

    dvs_slew_ctrl #(.NCH(NCH)) u_dvs_slew_ctrl (
        .clk(clk), .rst(rst), .tick(tick), .pair_mode(pair_mode),
        .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel), .wr_data(wr_data),
        .stby_pin(stby_pin), .dvs_pin(dvs_pin), .code_o(code_o), .pwr_rdy(pwr_rdy)
    );

    function automatic int tgt_of(int c);
        if (dvs_pin[c]) return m_dvs[c];
        if (stby_pin[c]) return m_stby[c];
        return m_norm[c];
    endfunction

    function automatic int code_of(int c);
        return int'(code_o[c*CW +: CW]);
    endfunction

    task automatic check(string tag, int act, int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // cycle model built from R2..R8
    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (rst) begin
                m_norm[c] = 0; m_stby[c] = 0; m_dvs[c] = 0; m_spd[c] = 0;
                m_code[c] = 0; m_cnt[c] = 0;
            end else begin
                int t;
                t = tgt_of(c);
                if (m_code[c] == t) m_cnt[c] = 0;
                else if (tick) begin
                    if (m_cnt[c] >= (1 << m_spd[c]) - 1) begin
                        m_cnt[c] = 0;
                        m_code[c] = m_code[c] + ((t > m_code[c]) ? 1 : -1);
                    end else m_cnt[c] = m_cnt[c] + 1;
                end
                if (wr_en && int'(wr_ch) == c && !(pair_mode && (c % 2 == 1))) begin
                    int v;
                    v = (int'(wr_data) > 32) ? 32 : int'(wr_data);
                    case (wr_sel)
                        2'd0: m_norm[c] = v;
                        2'd1: m_stby[c] = v;
                        2'd2: m_dvs[c]  = v;
                        default: m_spd[c] = int'(wr_data[1:0]);
                    endcase
                end
            end
        end
    end

    always @(negedge clk) begin
        if (mon_on && !rst) begin
            for (int c = 0; c < NCH; c++) begin
                check("R4 R6 code vs model", code_of(c), m_code[c]);
                check("R5 ready vs model", int'(pwr_rdy[c]), (m_code[c] == tgt_of(c)) ? 1 : 0);
            end
        end
    end

    task automatic wr(int c, int sel, int data);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_ch = 1'(c); wr_sel = 2'(sel); wr_data = CW'(data);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // edges after the capturing edge until ready is seen
    task automatic measure(int c, output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!pwr_rdy[c] && n < 2000);
    endtask

    task automatic settle(int c);
        int n;
        measure(c, n);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            check("R1 code in reset", code_of(c), 0);
            check("R1 ready in reset", int'(pwr_rdy[c]), 1);
        end
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            check("R1 code after reset", code_of(c), 0);
            check("R1 ready after reset", int'(pwr_rdy[c]), 1);
        end
        mon_on = 1;

        // R4/R5: spans 1,3,7 up and down at every speed
        for (int s = 0; s < 4; s++) begin
            wr(0, 3, s);
            for (int k = 0; k < 3; k++) begin
                int d;
                d = (k == 0) ? 1 : (k == 1) ? 3 : 7;
                wr(0, 0, d);
                measure(0, n);
                check("R4 rise duration", n, d * (1 << s));
                check("R5 rise final code", code_of(0), d);
                wr(0, 0, 0);
                measure(0, n);
                check("R4 fall duration", n, d * (1 << s));
                check("R5 fall final code", code_of(0), 0);
            end
        end
        // second channel alone, speed 2
        wr(1, 3, 2);
        wr(1, 0, 5);
        measure(1, n);
        check("R4 channel 1 duration", n, 20);
        check("R4 channel 0 untouched", code_of(0), 0);

        // R2: every write value, clamped at 32
        wr(0, 3, 0);
        for (int v = 0; v < 64; v++) begin
            wr(0, 0, v);
            settle(0);
            check("R2 clamped set point", code_of(0), (v > 32) ? 32 : v);
        end
        wr(0, 0, 0);
        settle(0);

        // R3: pin priority
        wr(0, 0, 4); wr(0, 1, 12); wr(0, 2, 28);
        for (int p = 0; p < 4; p++) begin
            @(posedge clk); #1;
            stby_pin[0] = p[0]; dvs_pin[0] = p[1];
            settle(0);
            check("R3 pin select", code_of(0), p[1] ? 28 : (p[0] ? 12 : 4));
        end
        stby_pin = '0; dvs_pin = '0;
        settle(0);
        wr(0, 0, 0);
        settle(0);

        // R6: reversal mid-ramp
        wr(0, 0, 20);
        repeat (6) @(posedge clk); #1;
        check("R6 mid-ramp code", code_of(0), 6);
        wr(0, 0, 2);
        check("R6 code at reversal", code_of(0), 8);
        measure(0, n);
        check("R6 reversal duration", n, 6);
        check("R6 final code", code_of(0), 2);

        // R7: pairing locks odd channel
        pair_mode = 1'b1;
        wr(1, 0, 30);
        wr(1, 3, 0);
        repeat (40) @(posedge clk);
        @(negedge clk);
        check("R7 locked code held", code_of(1), 5);
        check("R7 locked ready high", int'(pwr_rdy[1]), 1);
        wr(0, 0, 9);
        settle(0);
        check("R7 even channel writes", code_of(0), 9);
        pair_mode = 1'b0;
        wr(1, 0, 30);
        measure(1, n);
        check("R7 unlocked write duration", n, 100);
        check("R7 unlocked final code", code_of(1), 30);

        // R8: timebase held off, then sparse ticks
        wr(0, 3, 1);
        @(posedge clk); #1; tick = 1'b0;
        wr(0, 0, 14);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check("R8 no tick, code held", code_of(0), 9);
        check("R8 no tick, ready low", int'(pwr_rdy[0]), 0);
        for (int k = 0; k < 60; k++) begin
            @(posedge clk); #1;
            tick = (k % 3 == 0);
        end
        tick = 1'b1;
        @(negedge clk);
        check("R8 sparse ticks final code", code_of(0), 14);

        repeat (5) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule